// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative translation cache. Each slot maps a virtual page number, tagged with an address-space identifier, to a physical frame number. It also stores two permission flags (write allowed, execute allowed) and a modified flag. A lookup compares its key against every slot in the same cycle. One cycle later it returns a registered result that says hit, miss or permission fault. A miss is only reported as an exception-style indication; resolving it (walking the page tables) is left to the requester. The requester then installs the translation through the fill port.

Because every slot carries an address-space tag, translations of several processes can sit in the cache together and survive context switches. For the eager option, a one-cycle flush clears every slot. A one-cycle selective invalidate removes only the slots of one address space. When a fill needs a slot, an empty slot is taken first. Otherwise the least recently used slot is replaced, tracked by per-slot age counters. The slot count `ENTRIES` is meant to be 32, 64 or 128.

Lookup requests and lookup results are valid/ready streams, and fills use a valid/ready request. A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. `lk_ready` is low while an unconsumed result is held with `rs_ready` low, while a fill request is pending, and while a flush or invalidate is asserted. A result stays stable until it is taken with `rs_ready`. A fill is accepted when `fl_valid` and `fl_ready` are high. `fl_ready` is low only while a flush or invalidate is asserted. The flush and invalidate pins are plain one-cycle strobes.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty: `rs_valid` is 0, `lk_ready` is 1, and any lookup reports a miss (`rs_miss`=1, `rs_hit`=0, `rs_fault`=0).
- R2: A lookup whose page number and address-space tag match a valid slot, and whose access is permitted, reports `rs_hit`=1 with that slot's frame number. `rs_valid` rises on the clock edge that accepts the request.
- R3: A slot matches only when its address-space tag equals `lk_asid`. Two slots holding the same page number under different tags coexist, and each returns its own frame number; a third tag misses.
- R4: The access type `lk_op` is 2'b00 read, 2'b01 write, 2'b10 execute (2'b11 behaves as read). A write to a slot with `fl_wr_ok`=0, or an execute on a slot with `fl_ex_ok`=0, reports `rs_fault`=1 with `rs_hit`=0. Reads are always permitted. Exactly one of hit, miss and fault is set in every result.
- R5: A fill clears the slot's modified flag. A permitted write hit sets it, and `rs_dirty` reports the flag as it stands after the access.
- R6: A `flush_all` strobe empties every slot in one cycle, so later lookups miss.
- R7: An `inv_en` strobe empties, in one cycle, exactly the slots whose tag equals `inv_asid`; slots of other tags stay usable.
- R8: A fill whose page number and tag are already present overwrites that slot in place, so a later lookup returns the new frame number and never matches two slots.
- R9: A fill with no match takes an empty slot if one exists. With all slots valid, it replaces the slot least recently filled or hit (faults and misses do not count as use).
- R10: A result held with `rs_ready`=0 keeps its value and blocks new lookups (`lk_ready`=0). A pending fill request also blocks lookups. During a flush or invalidate, `fl_ready` and `lk_ready` are 0 and the request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_op | input | 2 | Access type: 00 read, 01 write, 10 execute |
| rs_valid | output | 1 | Lookup result valid |
| rs_ready | input | 1 | Consumer takes the result when high |
| rs_hit | output | 1 | Translation found and permitted |
| rs_miss | output | 1 | No matching slot (exception indication) |
| rs_fault | output | 1 | Matching slot forbids the access |
| rs_pfn | output | PFN_W | Physical frame number (0 on miss) |
| rs_dirty | output | 1 | Modified flag of the slot after the access |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill accepted when high |
| fl_vpn | input | VPN_W | Page number to install |
| fl_asid | input | ASID_W | Address-space tag to install |
| fl_pfn | input | PFN_W | Frame number to install |
| fl_wr_ok | input | 1 | Write permitted |
| fl_ex_ok | input | 1 | Execute permitted |
| flush_all | input | 1 | Empty every slot |
| inv_en | input | 1 | Empty slots of one address space |
| inv_asid | input | ASID_W | Address space to invalidate |

## Verification
The replacement tests fill every slot and then touch the oldest one, so a design that replaced by fill order, or that ignored hits when ageing, would evict a translation still in use. A second full-table test empties one slot by selective invalidate before a fill. Here a design that went straight to the age-based victim would drop the oldest live translation. The permission tests pair each forbidden access with a permitted one on the same slot, which catches a swapped write/execute check or a fault that still reports a hit. A dropped in-place refill shows up as a stale or merged frame number. Back-pressure tests hold the result for several cycles and present a second key, so a design that overwrote its result register or took the request early returns the wrong frame number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      valid_vec,
  input  logic [VPN_W-1:0]  vpn_tab [N],
  input  logic [ASID_W-1:0] asid_tab [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      hit_vec,
  output logic              any_hit,
  output logic [IDX_W-1:0]  hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (vpn_tab[g] == key_vpn) && (asid_tab[g] == key_asid);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  // R8: a key never matches more than one slot
  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N      = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [IDX_W-1:0] age [N];
  logic [N-1:0]     oldest_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (age[g] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oldest_vec[i]) victim_idx = victim_idx | IDX_W'(i);
    end
  end

  // R9: the age counters always name exactly one oldest slot
  assert_lru_single_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
  parameter int N      = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [IDX_W-1:0] lru_idx,
  output logic [IDX_W-1:0] alloc_idx
);
  logic             have_free;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
    alloc_idx = have_free ? free_idx : lru_idx;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_op,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic              rs_miss,
  output logic              rs_fault,
  output logic [PFN_W-1:0]  rs_pfn,
  output logic              rs_dirty,
  input  logic              fl_valid,
  output logic              fl_ready,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [PFN_W-1:0]  fl_pfn,
  input  logic              fl_wr_ok,
  input  logic              fl_ex_ok,
  input  logic              flush_all,
  input  logic              inv_en,
  input  logic [ASID_W-1:0] inv_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  // slot storage
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] dirty_vec;
  logic [ENTRIES-1:0] wr_ok_vec;
  logic [ENTRIES-1:0] ex_ok_vec;
  logic [VPN_W-1:0]   vpn_tab  [ENTRIES];
  logic [ASID_W-1:0]  asid_tab [ENTRIES];
  logic [PFN_W-1:0]   pfn_tab  [ENTRIES];

  // handshakes
  logic maint, fl_fire, lk_fire;
  assign maint    = flush_all | inv_en;
  assign fl_ready = !maint;
  assign fl_fire  = fl_valid && fl_ready;
  assign lk_ready = (!rs_valid || rs_ready) && !fl_valid && !maint;
  assign lk_fire  = lk_valid && lk_ready;

  // lookup match
  logic [ENTRIES-1:0] lk_hit_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .vpn_tab(vpn_tab), .asid_tab(asid_tab),
    .key_vpn(lk_vpn), .key_asid(lk_asid),
    .hit_vec(lk_hit_vec), .any_hit(lk_any), .hit_idx(lk_idx));

  // fill match (in-place refill)
  logic [ENTRIES-1:0] fl_hit_vec;
  logic               fl_any;
  logic [IDX_W-1:0]   fl_match_idx;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .vpn_tab(vpn_tab), .asid_tab(asid_tab),
    .key_vpn(fl_vpn), .key_asid(fl_asid),
    .hit_vec(fl_hit_vec), .any_hit(fl_any), .hit_idx(fl_match_idx));

  // victim choice
  logic             touch;
  logic [IDX_W-1:0] touch_idx, lru_idx, alloc_idx, fill_idx;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .victim_idx(lru_idx));

  tlb_alloc #(.N(ENTRIES)) u_alloc (
    .valid_vec(valid_vec), .lru_idx(lru_idx), .alloc_idx(alloc_idx));

  assign fill_idx = fl_any ? fl_match_idx : alloc_idx;

  // permission check
  acc_op_e op;
  logic    perm_bad, lk_good, lk_wr;
  assign op = acc_op_e'(lk_op);

  always_comb begin
    unique case (op)
      ACC_WRITE: perm_bad = !wr_ok_vec[lk_idx];
      ACC_EXEC:  perm_bad = !ex_ok_vec[lk_idx];
      default:   perm_bad = 1'b0;
    endcase
  end

  assign lk_wr   = (op == ACC_WRITE);
  assign lk_good = lk_any && !perm_bad;

  assign touch     = fl_fire || (lk_fire && lk_good);
  assign touch_idx = fl_fire ? fill_idx : lk_idx;

  // slot update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
      dirty_vec <= '0;
      wr_ok_vec <= '0;
      ex_ok_vec <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_tab[i]  <= '0;
        asid_tab[i] <= '0;
        pfn_tab[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all) begin
          valid_vec[i] <= 1'b0;
        end else if (inv_en) begin
          if (asid_tab[i] == inv_asid) valid_vec[i] <= 1'b0;
        end else if (fl_fire && fill_idx == IDX_W'(i)) begin
          valid_vec[i] <= 1'b1;
          dirty_vec[i] <= 1'b0;
          wr_ok_vec[i] <= fl_wr_ok;
          ex_ok_vec[i] <= fl_ex_ok;
          vpn_tab[i]   <= fl_vpn;
          asid_tab[i]  <= fl_asid;
          pfn_tab[i]   <= fl_pfn;
        end else if (lk_fire && lk_good && lk_wr && lk_idx == IDX_W'(i)) begin
          dirty_vec[i] <= 1'b1;
        end
      end
    end
  end

  // registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_fault <= 1'b0;
      rs_pfn   <= '0;
      rs_dirty <= 1'b0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_hit   <= lk_good;
      rs_miss  <= !lk_any;
      rs_fault <= lk_any && perm_bad;
      rs_pfn   <= lk_any ? pfn_tab[lk_idx] : '0;
      rs_dirty <= lk_any && (dirty_vec[lk_idx] || (lk_good && lk_wr));
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  // invalidate tracking for checking
  logic              inv_pend;
  logic [ASID_W-1:0] inv_last;
  logic [ENTRIES-1:0] stale_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_pend <= 1'b0;
      inv_last <= '0;
    end else begin
      inv_pend <= inv_en;
      inv_last <= inv_asid;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_stale
    assign stale_vec[g] = valid_vec[g] && (asid_tab[g] == inv_last);
  end

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  assert_inv_clears_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pend |-> (stale_vec == '0));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_pfn) && $stable(rs_hit) && $stable(rs_miss)));

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1));

  assert_no_take_in_maint_R10: assert property (@(posedge clk) disable iff (!rst_n)
    maint |-> (!fl_ready && !lk_ready));
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_op = 2'b00;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_hit, rs_miss, rs_fault, rs_dirty;
  logic [19:0] rs_pfn;
  logic        fl_valid = 1'b0;
  logic        fl_ready;
  logic [19:0] fl_vpn = '0;
  logic [7:0]  fl_asid = '0;
  logic [19:0] fl_pfn = '0;
  logic        fl_wr_ok = 1'b0;
  logic        fl_ex_ok = 1'b0;
  logic        flush_all = 1'b0;
  logic        inv_en = 1'b0;
  logic [7:0]  inv_asid = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_op(lk_op),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_miss(rs_miss),
    .rs_fault(rs_fault), .rs_pfn(rs_pfn), .rs_dirty(rs_dirty),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_vpn(fl_vpn), .fl_asid(fl_asid),
    .fl_pfn(fl_pfn), .fl_wr_ok(fl_wr_ok), .fl_ex_ok(fl_ex_ok),
    .flush_all(flush_all), .inv_en(inv_en), .inv_asid(inv_asid));

  function automatic logic [19:0] frame_of(logic [19:0] vpn, logic [7:0] asid);
    return vpn + 20'h00100 * asid + 20'h00055;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] pfn, logic w, logic x);
    @(negedge clk);
    fl_valid = 1; fl_vpn = vpn; fl_asid = asid; fl_pfn = pfn; fl_wr_ok = w; fl_ex_ok = x;
    while (!fl_ready) @(negedge clk);
    @(negedge clk);
    fl_valid = 0;
  endtask

  // issues one lookup; results are sampled at the negedge after acceptance
  task automatic lookup(logic [19:0] vpn, logic [7:0] asid, logic [1:0] op);
    @(negedge clk);
    rs_ready = 1; lk_valid = 1; lk_vpn = vpn; lk_asid = asid; lk_op = op;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic expect_hit(string req, logic [19:0] vpn, logic [7:0] asid, logic [1:0] op,
                            logic [19:0] pfn);
    lookup(vpn, asid, op);
    check(req, {31'd0, rs_valid}, 32'd1);
    check(req, {29'd0, rs_hit, rs_miss, rs_fault}, 32'b100);
    check(req, {12'd0, rs_pfn}, {12'd0, pfn});
  endtask

  task automatic expect_miss(string req, logic [19:0] vpn, logic [7:0] asid);
    lookup(vpn, asid, 2'b00);
    check(req, {29'd0, rs_hit, rs_miss, rs_fault}, 32'b010);
  endtask

  task automatic do_flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic do_inv(logic [7:0] asid);
    @(negedge clk); inv_en = 1; inv_asid = asid;
    @(negedge clk); inv_en = 0;
  endtask

  task automatic t_reset();
    check("R1 rs_valid after reset", {31'd0, rs_valid}, 32'd0);
    check("R1 lk_ready after reset", {31'd0, lk_ready}, 32'd1);
    expect_miss("R1 empty lookup", 20'h3, 8'd1);
  endtask

  task automatic t_basic();
    fill(20'h12, 8'd1, frame_of(20'h12, 8'd1), 1, 1);
    expect_hit("R2 basic hit", 20'h12, 8'd1, 2'b00, frame_of(20'h12, 8'd1));
    @(negedge clk);
    check("R2 result taken", {31'd0, rs_valid}, 32'd0);
  endtask

  task automatic t_asid();
    fill(20'h12, 8'd2, frame_of(20'h12, 8'd2), 1, 1);
    expect_hit("R3 tag 1", 20'h12, 8'd1, 2'b00, frame_of(20'h12, 8'd1));
    expect_hit("R3 tag 2", 20'h12, 8'd2, 2'b00, frame_of(20'h12, 8'd2));
    expect_miss("R3 tag 3", 20'h12, 8'd3);
  endtask

  task automatic t_perm();
    fill(20'h40, 8'd1, frame_of(20'h40, 8'd1), 0, 1);
    lookup(20'h40, 8'd1, 2'b01);
    check("R4 write no-permit fault", {29'd0, rs_hit, rs_miss, rs_fault}, 32'b001);
    expect_hit("R4 read permitted", 20'h40, 8'd1, 2'b00, frame_of(20'h40, 8'd1));
    expect_hit("R4 exec permitted", 20'h40, 8'd1, 2'b10, frame_of(20'h40, 8'd1));
    check("R5 no write no dirty", {31'd0, rs_dirty}, 32'd0);
    fill(20'h41, 8'd1, frame_of(20'h41, 8'd1), 1, 0);
    lookup(20'h41, 8'd1, 2'b10);
    check("R4 exec no-permit fault", {29'd0, rs_hit, rs_miss, rs_fault}, 32'b001);
    check("R5 fresh fill clean", {31'd0, rs_dirty}, 32'd0);
    expect_hit("R4 write permitted", 20'h41, 8'd1, 2'b01, frame_of(20'h41, 8'd1));
    check("R5 write sets dirty", {31'd0, rs_dirty}, 32'd1);
    expect_hit("R5 dirty persists", 20'h41, 8'd1, 2'b00, frame_of(20'h41, 8'd1));
    check("R5 dirty persists", {31'd0, rs_dirty}, 32'd1);
    fill(20'h41, 8'd1, 20'h77777, 1, 0);
    expect_hit("R8 refill in place", 20'h41, 8'd1, 2'b00, 20'h77777);
    check("R5 refill clears dirty", {31'd0, rs_dirty}, 32'd0);
  endtask

  task automatic t_inv();
    do_inv(8'd2);
    expect_miss("R7 invalidated tag", 20'h12, 8'd2);
    expect_hit("R7 other tag kept", 20'h12, 8'd1, 2'b00, frame_of(20'h12, 8'd1));
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rs_ready = 0; lk_valid = 1; lk_vpn = 20'h12; lk_asid = 8'd1; lk_op = 2'b00;
    @(negedge clk);
    check("R10 first result valid", {31'd0, rs_valid}, 32'd1);
    check("R10 first result pfn", {12'd0, rs_pfn}, {12'd0, frame_of(20'h12, 8'd1)});
    check("R10 lk_ready low while held", {31'd0, lk_ready}, 32'd0);
    lk_vpn = 20'h40;
    @(negedge clk);
    check("R10 held result stable", {12'd0, rs_pfn}, {12'd0, frame_of(20'h12, 8'd1)});
    check("R10 held result valid", {31'd0, rs_valid}, 32'd1);
    rs_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    check("R10 second result pfn", {12'd0, rs_pfn}, {12'd0, frame_of(20'h40, 8'd1)});
    @(negedge clk);
    check("R10 second result taken", {31'd0, rs_valid}, 32'd0);
    fl_valid = 1; fl_vpn = 20'h12; fl_asid = 8'd1; fl_pfn = 20'h1; fl_wr_ok = 0; fl_ex_ok = 0;
    #1;
    check("R10 fill blocks lookup", {31'd0, lk_ready}, 32'd0);
    fl_valid = 0;
    #1;
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush_all = 1;
    fl_valid = 1; fl_vpn = 20'h99; fl_asid = 8'd1; fl_pfn = 20'h99; fl_wr_ok = 1; fl_ex_ok = 1;
    #1;
    check("R10 fl_ready low in flush", {31'd0, fl_ready}, 32'd0);
    check("R10 lk_ready low in flush", {31'd0, lk_ready}, 32'd0);
    @(negedge clk);
    flush_all = 0; fl_valid = 0;
    expect_miss("R6 flushed 0x12", 20'h12, 8'd1);
    expect_miss("R6 flushed 0x40", 20'h40, 8'd1);
    expect_miss("R10 fill during flush not taken", 20'h99, 8'd1);
  endtask

  task automatic t_lru();
    do_flush();
    for (int i = 0; i < N; i++) fill(20'(i), 8'd1, frame_of(20'(i), 8'd1), 1, 1);
    expect_hit("R9 touch oldest", 20'h0, 8'd1, 2'b00, frame_of(20'h0, 8'd1));
    fill(20'h100, 8'd1, frame_of(20'h100, 8'd1), 1, 1);
    expect_miss("R9 LRU evicted", 20'h1, 8'd1);
    expect_hit("R9 touched kept", 20'h0, 8'd1, 2'b00, frame_of(20'h0, 8'd1));
    expect_hit("R9 new entry", 20'h100, 8'd1, 2'b00, frame_of(20'h100, 8'd1));
    expect_hit("R9 others kept", 20'h2, 8'd1, 2'b00, frame_of(20'h2, 8'd1));
  endtask

  task automatic t_free_first();
    do_flush();
    for (int i = 0; i < N; i++) begin
      logic [7:0] a;
      a = (i == 5) ? 8'd2 : 8'd1;
      fill(20'(i), a, frame_of(20'(i), a), 1, 1);
    end
    do_inv(8'd2);
    fill(20'h200, 8'd1, frame_of(20'h200, 8'd1), 1, 1);
    expect_hit("R9 empty slot used, oldest kept", 20'h0, 8'd1, 2'b00, frame_of(20'h0, 8'd1));
    expect_hit("R9 new in empty slot", 20'h200, 8'd1, 2'b00, frame_of(20'h200, 8'd1));
    expect_miss("R7 invalidated entry gone", 20'h5, 8'd2);
    expect_hit("R7 neighbour kept", 20'h6, 8'd1, 2'b00, frame_of(20'h6, 8'd1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_asid();
    t_perm();
    t_inv();
    t_backpressure();
    t_flush();
    t_lru();
    t_free_first();
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule